// File: doc/BRIEF.md
# Matrix Keypad Scanner

The scanner walks a 4×4 switch matrix one row at a time. It pulls a single row line low and reads the four column lines, which idle high through external pull-ups. When a key closes, the scanner checks the closure again after a debounce window. If the check agrees, it reports the key once on a five-bit output: a `key_valid` pulse of fixed length and a 4-bit key code. It then waits until the matrix has stayed quiet for a release window before it resumes scanning with the next row.

All sequencing lives in one state machine. A single down-counter times every phase and is reloaded with a different length on each phase entry: row settle, press confirmation, strobe and release quiet time. Each length is a parameter counted in clock cycles. The defaults suit a 50 MHz clock: 1 ms settle, 10 ms confirmation, 0.5 ms strobe and 20 ms release. The column inputs pass through a two-flop synchroniser before the state machine uses them.

The output has no ready signal and so no back-pressure. A consumer must capture the code while `key_valid` is high, and the code is held steady for the whole pulse. When more than one column of the driven row reads low, the lowest-numbered column is taken.

Top module: `kp_scanner`

## Requirements
- R1: While reset is applied and right after it, `row_n` is 4'b1110 (row 0 driven), and `key_valid`, `key_code` and `dbg` are zero.
- R2: Exactly one bit of `row_n` is low at any time. With no key pressed, the driven row steps 0→1→2→3→0, and each row is held for SETTLE_CYC cycles.
- R3: The key code depends on the driven row r (`row_n[r]` low) and the low column c (`col_n[c]` low). Row 3, columns 3..0: 1, 2, 3, A. Row 2: 4, 5, 6, B. Row 1: 7, 8, 9, C. Row 0: E, 0, F, D.
- R4: One press yields exactly one report, however long the key is held.
- R5: `key_valid` stays high for exactly STROBE_CYC cycles per report, and `key_code` does not change while it is high.
- R6: A report is made only if the same code is read again PRESS_CYC cycles after the first detection. A key released or replaced within that window gives no report.
- R7: Scanning resumes only after all columns have read high for RELEASE_CYC consecutive cycles. Any low column restarts that count, and no second report can occur before it completes.
- R8: `dbg` always equals {`key_valid`, `key_code`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| col_n | input | 4 | Column lines, low while a key in the driven row is closed |
| row_n | output | 4 | Row drive, one bit low at a time, others released high |
| key_valid | output | 1 | Report strobe, STROBE_CYC cycles long |
| key_code | output | 4 | Code of the reported key |
| dbg | output | 5 | Copy of {key_valid, key_code} |

## Verification
All sixteen keys are pressed one at a time and held well past the strobe. This separates the code mapping from the single-report rule, because a wrong code and a repeated report show up as different scoreboard mismatches. Two short-lived closures aimed at a chosen row's settle window test confirmation: one key is released early, and in the other a second key in the same row replaces the first. Neither may reach the output. A press whose release chatters with gaps shorter than the release window shows whether the quiet-time counter restarts rather than resuming scanning early. An idle run first checks the row rotation order and dwell time.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_ROWS = 4;
  localparam int KP_COLS = 4;
  localparam int KP_RW   = $clog2(KP_ROWS);
  localparam int KP_CW   = $clog2(KP_COLS);

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_CONFIRM = 3'd2,
    ST_STROBE  = 3'd3,
    ST_RELEASE = 3'd4
  } kp_state_e;

  // Key legend: row index r (row_n[r] low), column index c (col_n[c] low)
  function automatic logic [3:0] kp_code(input logic [KP_RW-1:0] r,
                                         input logic [KP_CW-1:0] c);
    logic [3:0] v;
    case ({r, c})
      4'b11_11: v = 4'h1;  4'b11_10: v = 4'h2;  4'b11_01: v = 4'h3;  4'b11_00: v = 4'hA;
      4'b10_11: v = 4'h4;  4'b10_10: v = 4'h5;  4'b10_01: v = 4'h6;  4'b10_00: v = 4'hB;
      4'b01_11: v = 4'h7;  4'b01_10: v = 4'h8;  4'b01_01: v = 4'h9;  4'b01_00: v = 4'hC;
      4'b00_11: v = 4'hE;  4'b00_10: v = 4'h0;  4'b00_01: v = 4'hF;  default:  v = 4'hD;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stage[s] <= '1;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/kp_timer.sv
module kp_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/kp_col_pick.sv
module kp_col_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  col_n,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (!col_n[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
  import kp_pkg::*;
#(
  parameter int SETTLE_CYC  = 50000,
  parameter int PRESS_CYC   = 500000,
  parameter int STROBE_CYC  = 25000,
  parameter int RELEASE_CYC = 1000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KP_COLS-1:0]  col_n,
  output logic [KP_ROWS-1:0]  row_n,
  output logic                key_valid,
  output logic [3:0]          key_code,
  output logic [4:0]          dbg
);
  localparam int MAX_A   = (SETTLE_CYC > PRESS_CYC) ? SETTLE_CYC : PRESS_CYC;
  localparam int MAX_B   = (STROBE_CYC > RELEASE_CYC) ? STROBE_CYC : RELEASE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [TW-1:0] L_SETTLE  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] L_PRESS   = TW'(PRESS_CYC - 1);
  localparam logic [TW-1:0] L_STROBE  = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] L_RELEASE = TW'(RELEASE_CYC - 1);

  kp_state_e          state;
  logic [KP_RW-1:0]   row_idx;
  logic [3:0]         held_code;
  logic               valid_q;

  logic [KP_COLS-1:0] col_s;
  logic               col_hit;
  logic [KP_CW-1:0]   col_idx;
  logic [3:0]         cur_code;
  logic               t_load;
  logic [TW-1:0]      t_val;
  logic               t_done;

  kp_sync #(.W(KP_COLS), .STAGES(2)) u_sync (
    .clk (clk), .rst (rst), .d (col_n), .q (col_s)
  );

  kp_col_pick #(.N(KP_COLS)) u_pick (
    .col_n (col_s), .hit (col_hit), .idx (col_idx)
  );

  kp_timer #(.W(TW)) u_timer (
    .clk (clk), .rst (rst), .load (t_load), .load_val (t_val), .done (t_done)
  );

  assign cur_code = kp_code(row_idx, col_idx);

  // Timer reload per phase entry
  always_comb begin
    t_load = 1'b0;
    t_val  = L_SETTLE;
    case (state)
      ST_INIT: begin
        t_load = 1'b1;
        t_val  = L_SETTLE;
      end
      ST_SETTLE: if (t_done) begin
        t_load = 1'b1;
        t_val  = col_hit ? L_PRESS : L_SETTLE;
      end
      ST_CONFIRM: if (t_done) begin
        t_load = 1'b1;
        t_val  = (col_hit && cur_code == held_code) ? L_STROBE : L_RELEASE;
      end
      ST_STROBE: if (t_done) begin
        t_load = 1'b1;
        t_val  = L_RELEASE;
      end
      ST_RELEASE: if (col_hit || t_done) begin
        t_load = 1'b1;
        t_val  = col_hit ? L_RELEASE : L_SETTLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= ST_INIT;
      row_idx   <= '0;
      held_code <= '0;
      valid_q   <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          row_idx   <= '0;
          held_code <= '0;
          valid_q   <= 1'b0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: if (t_done) begin
          if (col_hit) begin
            held_code <= cur_code;
            state     <= ST_CONFIRM;
          end else begin
            row_idx <= row_idx + 1'b1;
          end
        end
        ST_CONFIRM: if (t_done) begin
          if (col_hit && cur_code == held_code) begin
            valid_q <= 1'b1;
            state   <= ST_STROBE;
          end else begin
            state <= ST_RELEASE;
          end
        end
        ST_STROBE: if (t_done) begin
          valid_q <= 1'b0;
          state   <= ST_RELEASE;
        end
        ST_RELEASE: if (!col_hit && t_done) begin
          row_idx <= row_idx + 1'b1;
          state   <= ST_SETTLE;
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  genvar r;
  generate
    for (r = 0; r < KP_ROWS; r++) begin : g_row
      assign row_n[r] = (row_idx != KP_RW'(r));
    end
  endgenerate

  assign key_valid = valid_q;
  assign key_code  = held_code;
  assign dbg       = {valid_q, held_code};
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk #(
  parameter int STROBE_CYC = 25000
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] col_n,
  input logic [3:0] row_n,
  input logic       key_valid,
  input logic [3:0] key_code,
  input logic [4:0] dbg
);
  int run_len;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            run_len <= 0;
    else if (key_valid) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  // R2: one row driven at a time
  p_one_row_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~row_n) == 1);

  // R2: the row does not move while a report is out
  p_row_held_r2: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $stable(row_n));

  // R5: strobe length
  p_strobe_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(key_valid) |-> run_len == STROBE_CYC);

  // R5: code steady during strobe
  p_code_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (key_valid && $past(key_valid)) |-> $stable(key_code));

  // R6: a report follows a column seen low at the confirming sample
  p_press_seen_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> $past(col_n, 3) != 4'hF);

  // R8: debug copy tracks the report outputs
  p_dbg_r8: assert property (@(posedge clk) disable iff (rst)
    dbg[4] == key_valid && dbg[3:0] == key_code);
endmodule

bind kp_scanner kp_scanner_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk (clk), .rst (rst), .col_n (col_n), .row_n (row_n),
  .key_valid (key_valid), .key_code (key_code), .dbg (dbg)
);

// File: tb/kp_scanner_bench.sv
module kp_scanner_bench;
  localparam int SET = 8;
  localparam int PRS = 20;
  localparam int STB = 5;
  localparam int REL = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] col_n;
  logic [3:0] row_n;
  logic       key_valid;
  logic [3:0] key_code;
  logic [4:0] dbg;

  int tests = 0;
  int fails = 0;
  int strobes = 0;
  logic [3:0] expq [$];

  logic pressed = 1'b0;
  int   pr = 0;
  int   pc = 0;

  always #4 clk = ~clk;

  kp_scanner #(.SETTLE_CYC(SET), .PRESS_CYC(PRS), .STROBE_CYC(STB), .RELEASE_CYC(REL))
    u_kp_scanner (.clk(clk), .rst(rst), .col_n(col_n), .row_n(row_n),
                  .key_valid(key_valid), .key_code(key_code), .dbg(dbg));

  // Switch matrix model
  always_comb begin
    col_n = 4'hF;
    if (pressed && !row_n[pr]) col_n[pc] = 1'b0;
  end

  function automatic logic [3:0] legend(input int r, input int c);
    logic [3:0] v;
    case (r)
      3: v = (c == 3) ? 4'h1 : (c == 2) ? 4'h2 : (c == 1) ? 4'h3 : 4'hA;
      2: v = (c == 3) ? 4'h4 : (c == 2) ? 4'h5 : (c == 1) ? 4'h6 : 4'hB;
      1: v = (c == 3) ? 4'h7 : (c == 2) ? 4'h8 : (c == 1) ? 4'h9 : 4'hC;
      default: v = (c == 3) ? 4'hE : (c == 2) ? 4'h0 : (c == 1) ? 4'hF : 4'hD;
    endcase
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected codes, measures pulse length
  initial begin
    logic prev_v;
    int   len;
    prev_v = 1'b0;
    len = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (key_valid && !prev_v) begin
          strobes++;
          check(dbg == {1'b1, key_code}, "R8 dbg", dbg, {1'b1, key_code});
          if (expq.size() == 0) begin
            check(1'b0, "R4 unexpected report", key_code, 0);
          end else begin
            logic [3:0] e;
            e = expq.pop_front();
            check(key_code == e, "R3 code", key_code, e);
          end
          len = 0;
        end
        if (key_valid) len++;
        if (!key_valid && prev_v) check(len == STB, "R5 strobe length", len, STB);
        prev_v = key_valid;
      end
    end
  end

  task automatic wait_row(input int r);
    logic [3:0] p;
    p = row_n;
    forever begin
      @(negedge clk);
      if (!row_n[r] && p[r]) break;
      p = row_n;
    end
  endtask

  task automatic press_key(input int r, input int c);
    expq.push_back(legend(r, c));
    @(negedge clk);
    pr = r; pc = c; pressed = 1'b1;
    repeat (120) @(negedge clk);
    pressed = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(row_n == 4'b1110, "R1 row", row_n, 4'b1110);
    check(key_valid == 1'b0, "R1 valid", key_valid, 0);
    check(dbg == 5'd0, "R1 dbg", dbg, 0);
    rst = 1'b0;
    @(negedge clk);
    check(row_n == 4'b1110 && key_code == 4'h0, "R1 after reset", {row_n, key_code}, 8'hE0);

    // R2: idle rotation and dwell
    begin
      logic [3:0] p;
      int gap;
      p = row_n;
      gap = 0;
      for (int k = 0; k < 6; k++) begin
        do begin @(negedge clk); gap++; end while (row_n == p);
        check(row_n == {p[2:0], p[3]}, "R2 order", row_n, {p[2:0], p[3]});
        if (k > 0) check(gap == SET, "R2 dwell", gap, SET);
        p = row_n;
        gap = 0;
      end
    end

    // R3, R4: every key held long
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        press_key(r, c);
    check(expq.size() == 0, "R4 all keys reported", expq.size(), 0);

    // R6: closure released before confirmation
    s0 = strobes;
    wait_row(2);
    pr = 2; pc = 1; pressed = 1'b1;
    repeat (SET + 4) @(negedge clk);
    pressed = 1'b0;
    repeat (150) @(negedge clk);
    check(strobes == s0, "R6 short closure", strobes - s0, 0);

    // R6: different key at confirmation
    wait_row(1);
    pr = 1; pc = 3; pressed = 1'b1;
    repeat (SET + 4) @(negedge clk);
    pc = 0;
    repeat (40) @(negedge clk);
    pressed = 1'b0;
    repeat (150) @(negedge clk);
    check(strobes == s0, "R6 changed key", strobes - s0, 0);

    // R7: chattering release gives one report
    expq.push_back(legend(3, 2));
    pr = 3; pc = 2; pressed = 1'b1;
    repeat (120) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      pressed = 1'b0;
      repeat (REL - 10) @(negedge clk);
      pressed = 1'b1;
      repeat (4) @(negedge clk);
    end
    pressed = 1'b0;
    repeat (150) @(negedge clk);
    check(strobes == s0 + 1, "R7 one report through chatter", strobes - s0, 1);
    check(expq.size() == 0, "R7 queue drained", expq.size(), 0);

    // R7: scanning resumes after release
    begin
      logic [3:0] p;
      p = row_n;
      repeat (SET + 2) @(negedge clk);
      check(row_n != p, "R7 scan resumed", row_n, {p[2:0], p[3]});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule